// File: doc/BRIEF.md
# Miss status holding register file

This block keeps track of cache misses that are still outstanding. It holds a small pool of entries. Each live entry records a block address, a secure-world flag, a thread number and the time at which the miss may first go to memory. An entry is either pending, which means it waits to issue, or in service, which means it is already in flight downstream. A cache controller allocates an entry for each new miss. It uses the associative lookup ports to merge later accesses to the same block. It takes the next miss to send downstream from the issue port.

The pending entries form a ready order. Fronted entries come first, and the entry fronted most recently leads. All other pending entries follow in ascending ready time, and entries with equal times keep the order in which they were inserted. The head of this order is offered for issue once its ready time is no later than the current time. One command is accepted per clock. The commands are allocate, mark in service, return to pending, move to front, free, squash a thread, drain, and pop a target.

The pool has NUM_ENTRIES + RESERVE - 1 physical slots. The block reports full while the number of free slots is at or below RESERVE.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is allocated. The allocated and in-service counts are 0, full is 0, issue_valid is 0, both lookups miss, and alloc_idx is 0.
- R2: Command 0 (allocate) fills the lowest-numbered free slot, shown on alloc_idx, and adds one to alloc_cnt. With the default 5 slots and a reserve of 2, full rises after three allocations. An allocate while full changes no state and raises alloc_err for the next cycle only.
- R3: The lookup hits only on an allocated entry whose address and secure flag both equal lk_addr and lk_secure. lk_idx gives the lowest-numbered such entry, and lk_mask has one bit set for every such entry.
- R4: The pending lookup uses the same comparison but considers only entries that are allocated and not in service.
- R5: The ready order puts pending entries in ascending ready time, with equal times in insertion order. issue_valid is 1 only when the head's ready time is at or below now_time, and issue_idx names the head.
- R6: A cycle with issue_valid and issue_ready both high puts the head in service, and svc_cnt rises by one. issue_valid is 0 in any cycle with cmd_valid high.
- R7: Command 1 (mark in service) on a pending entry puts it in service when cmd_flag is 0. When cmd_flag is 1 it frees the entry instead.
- R8: Command 2 (return to pending) on an in-service entry clears its in-service state and lowers svc_cnt. The entry is reinserted by its ready time, after every pending entry with an equal time.
- R9: Command 4 (free) releases an allocated entry whether it is pending or in service, removes it from the ready order, and lowers alloc_cnt.
- R10: Command 3 (move to front) makes a pending entry the head of the ready order regardless of ready time. The entry fronted most recently leads. On an in-service entry the command has no effect.
- R11: Command 5 (squash) frees every pending entry whose thread equals cmd_tid. In-service entries of that thread stay allocated.
- R12: Command 6 (drain) with nothing allocated pulses drain_done for one cycle. Otherwise draining is set, and drain_done pulses in the cycle after the last entry is freed.
- R13: Command 7 (target pop) frees the entry when cmd_flag is 1, meaning no targets remain. unfull_pulse is 1 for one cycle when that free takes the block from full to not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (see R2 to R13) |
| cmd_idx | input | IW | Target slot for per-entry commands |
| cmd_addr | input | ADDR_W | Block address for allocate |
| cmd_secure | input | 1 | Secure flag for allocate |
| cmd_tid | input | TID_W | Thread for allocate and squash |
| cmd_time | input | TIME_W | Ready time for allocate |
| cmd_flag | input | 1 | Finish-now for mark in service; no-targets-left for target pop |
| now_time | input | TIME_W | Current time |
| lk_addr | input | ADDR_W | Lookup address |
| lk_secure | input | 1 | Lookup secure flag |
| lk_hit | output | 1 | Some allocated entry matches |
| lk_idx | output | IW | Lowest matching allocated entry |
| lk_mask | output | PHYS | All matching allocated entries |
| pd_hit | output | 1 | Some pending entry matches |
| pd_idx | output | IW | Lowest matching pending entry |
| issue_valid | output | 1 | The head is due for issue |
| issue_ready | input | 1 | The consumer takes the head |
| issue_idx | output | IW | Slot of the head |
| issue_addr | output | ADDR_W | Block address of the head |
| alloc_idx | output | IW | Slot the next allocate would use |
| full | output | 1 | Free slots at or below the reserve |
| alloc_cnt | output | CW | Allocated entries |
| svc_cnt | output | CW | In-service entries |
| alloc_err | output | 1 | The previous cycle's allocate was refused |
| unfull_pulse | output | 1 | The previous target pop cleared full |
| drain_done | output | 1 | Drain completion pulse |
| draining | output | 1 | A drain is waiting for the pool to empty |

## Verification
The ordering rule is tried against every assignment of ready times from {0,1,2} to three entries, 27 patterns in all. The set covers all-distinct times, full ties and partial ties, so a comparison that breaks ties the wrong way, or that sorts in the wrong direction, produces a different issue sequence. Directed sequences then give the lookup ports equal addresses that differ only in the secure flag, and entries that are partly in service, so the plain and pending lookups must give different answers. Further sequences re-pend an entry whose ready time equals another entry's, front several entries one after another, squash a thread that has both pending and in-service entries, and take the pool across the full boundary in both directions. Together these show where the reinsertion, front and count logic goes wrong.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
   typedef enum logic [2:0] {
      OP_ALLOC  = 3'd0,
      OP_MARK   = 3'd1,
      OP_PEND   = 3'd2,
      OP_FRONT  = 3'd3,
      OP_FREE   = 3'd4,
      OP_SQUASH = 3'd5,
      OP_DRAIN  = 3'd6,
      OP_TPOP   = 3'd7
   } mshr_op_e;
endpackage

// File: rtl/mshr_match.sv
// Associative compare of a query against every qualified slot.
module mshr_match #(
   parameter int unsigned ENTRIES   = 5,
   parameter int unsigned AW        = 16,
   parameter bit          PICK_HIGH = 1'b0,
   localparam int unsigned IW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0]         qual,
   input  logic [ENTRIES-1:0][AW-1:0] tag_addr,
   input  logic [ENTRIES-1:0]         tag_sec,
   input  logic [AW-1:0]              q_addr,
   input  logic                       q_sec,
   output logic [ENTRIES-1:0]         mask,
   output logic                       hit,
   output logic [IW-1:0]              idx
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign mask[g] = qual[g] && (tag_addr[g] == q_addr) && (tag_sec[g] == q_sec);
   end

   assign hit = |mask;

   if (PICK_HIGH) begin : g_pick_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < ENTRIES; i++)
            if (mask[i]) idx = IW'(i);
      end
   end else begin : g_pick_low
      always_comb begin
         idx = '0;
         for (int i = ENTRIES - 1; i >= 0; i--)
            if (mask[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/mshr_order.sv
// Ready order: fronted entries first (newest fronted leads), then
// ascending ready time, ties broken by insertion age matrix.
module mshr_order #(
   parameter int unsigned ENTRIES = 5,
   parameter int unsigned TW      = 8,
   localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ENTRIES-1:0]         pend,
   input  logic [ENTRIES-1:0][TW-1:0] rdy_time,
   input  logic [TW-1:0]              now_time,
   input  logic                       ins_v,
   input  logic [IW-1:0]              ins_idx,
   input  logic                       frt_v,
   input  logic [IW-1:0]              frt_idx,
   output logic [ENTRIES-1:0]         head_oh,
   output logic                       head_any,
   output logic [IW-1:0]              head_idx,
   output logic                       head_due
);
   // older_q[i][j]: slot i was (re)inserted before slot j
   logic [ENTRIES-1:0] older_q [ENTRIES];
   logic [ENTRIES-1:0] front_q;
   logic [ENTRIES-1:0] ahead   [ENTRIES];
   logic [IW-1:0]      upd_idx;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         for (int j = 0; j < ENTRIES; j++) begin
            if (i == j)
               ahead[i][j] = 1'b1;
            else if (front_q[i] != front_q[j])
               ahead[i][j] = front_q[i];
            else if (front_q[i])
               ahead[i][j] = older_q[j][i];
            else if (rdy_time[i] != rdy_time[j])
               ahead[i][j] = rdy_time[i] < rdy_time[j];
            else
               ahead[i][j] = older_q[i][j];
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_head
      assign head_oh[g] = pend[g] && (&(ahead[g] | ~pend));
   end

   always_comb begin
      head_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (head_oh[i]) head_idx = IW'(i);
   end

   assign head_any = |head_oh;
   assign head_due = head_any && (rdy_time[head_idx] <= now_time);
   assign upd_idx  = frt_v ? frt_idx : ins_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         front_q <= '0;
         for (int i = 0; i < ENTRIES; i++) older_q[i] <= '0;
      end else if (ins_v || frt_v) begin
         older_q[upd_idx] <= '0;
         for (int j = 0; j < ENTRIES; j++)
            if (IW'(j) != upd_idx) older_q[j][upd_idx] <= 1'b1;
         front_q[upd_idx] <= frt_v;
      end
   end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
   parameter int unsigned NUM_ENTRIES      = 4,
   parameter int unsigned RESERVE          = 2,
   parameter int unsigned ADDR_W           = 16,
   parameter int unsigned TID_W            = 2,
   parameter int unsigned TIME_W           = 8,
   parameter bit          LOOKUP_PICK_HIGH = 1'b0,
   localparam int unsigned PHYS = NUM_ENTRIES + RESERVE - 1,
   localparam int unsigned IW   = (PHYS > 1) ? $clog2(PHYS) : 1,
   localparam int unsigned CW   = $clog2(PHYS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [IW-1:0]     cmd_idx,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_secure,
   input  logic [TID_W-1:0]  cmd_tid,
   input  logic [TIME_W-1:0] cmd_time,
   input  logic              cmd_flag,
   input  logic [TIME_W-1:0] now_time,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_secure,
   output logic              lk_hit,
   output logic [IW-1:0]     lk_idx,
   output logic [PHYS-1:0]   lk_mask,
   output logic              pd_hit,
   output logic [IW-1:0]     pd_idx,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic [IW-1:0]     issue_idx,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [IW-1:0]     alloc_idx,
   output logic              full,
   output logic [CW-1:0]     alloc_cnt,
   output logic [CW-1:0]     svc_cnt,
   output logic              alloc_err,
   output logic              unfull_pulse,
   output logic              drain_done,
   output logic              draining
);
   import mshr_pkg::*;

   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("mshr_file: NUM_ENTRIES must be at least 2");
   end
   if (RESERVE < 1) begin : g_bad_reserve
      $error("mshr_file: RESERVE must be at least 1");
   end
   if (TIME_W < 2 || ADDR_W < 2) begin : g_bad_width
      $error("mshr_file: TIME_W and ADDR_W must be at least 2");
   end

   logic [PHYS-1:0]             vld_q, svc_q, vld_n, svc_n;
   logic [PHYS-1:0][ADDR_W-1:0] addr_q;
   logic [PHYS-1:0]             sec_q;
   logic [PHYS-1:0][TID_W-1:0]  tid_q;
   logic [PHYS-1:0][TIME_W-1:0] time_q;
   logic                        alloc_err_q, unfull_q, drain_done_q, draining_q;

   mshr_op_e      op;
   logic          sel_ok, wr_en, ins_v, frt_v, err_n, unfull_n, issue_fire;
   logic [IW-1:0] ins_idx;
   logic [PHYS-1:0] head_oh;
   logic          head_any, head_due;
   logic [IW-1:0] head_idx;
   int            free_cnt, next_cnt;

   assign op = mshr_op_e'(cmd_op);

   // lookups
   mshr_match #(.ENTRIES(PHYS), .AW(ADDR_W), .PICK_HIGH(LOOKUP_PICK_HIGH)) u_lk (
      .qual(vld_q), .tag_addr(addr_q), .tag_sec(sec_q),
      .q_addr(lk_addr), .q_sec(lk_secure),
      .mask(lk_mask), .hit(lk_hit), .idx(lk_idx));

   logic [PHYS-1:0] pd_mask;
   mshr_match #(.ENTRIES(PHYS), .AW(ADDR_W), .PICK_HIGH(LOOKUP_PICK_HIGH)) u_pd (
      .qual(vld_q & ~svc_q), .tag_addr(addr_q), .tag_sec(sec_q),
      .q_addr(lk_addr), .q_sec(lk_secure),
      .mask(pd_mask), .hit(pd_hit), .idx(pd_idx));

   // ready order
   mshr_order #(.ENTRIES(PHYS), .TW(TIME_W)) u_order (
      .clk(clk), .rst_n(rst_n), .pend(vld_q & ~svc_q), .rdy_time(time_q),
      .now_time(now_time), .ins_v(ins_v), .ins_idx(ins_idx),
      .frt_v(frt_v), .frt_idx(cmd_idx), .head_oh(head_oh),
      .head_any(head_any), .head_idx(head_idx), .head_due(head_due));

   // free slot pick and occupancy
   always_comb begin
      alloc_idx = '0;
      for (int i = PHYS - 1; i >= 0; i--)
         if (!vld_q[i]) alloc_idx = IW'(i);
   end

   assign alloc_cnt = CW'($countones(vld_q));
   assign svc_cnt   = CW'($countones(svc_q));
   assign free_cnt  = int'(PHYS) - int'(alloc_cnt);
   assign full      = free_cnt <= int'(RESERVE);

   assign issue_valid = !cmd_valid && head_due;
   assign issue_idx   = head_idx;
   assign issue_addr  = addr_q[head_idx];
   assign issue_fire  = issue_valid && issue_ready;

   assign sel_ok = (int'(cmd_idx) < int'(PHYS)) && vld_q[cmd_idx];

   always_comb begin
      vld_n    = vld_q;
      svc_n    = svc_q;
      wr_en    = 1'b0;
      ins_v    = 1'b0;
      ins_idx  = cmd_idx;
      frt_v    = 1'b0;
      err_n    = 1'b0;
      unfull_n = 1'b0;
      if (cmd_valid) begin
         unique case (op)
            OP_ALLOC: begin
               if (full) begin
                  err_n = 1'b1;
               end else begin
                  vld_n[alloc_idx] = 1'b1;
                  svc_n[alloc_idx] = 1'b0;
                  wr_en   = 1'b1;
                  ins_v   = 1'b1;
                  ins_idx = alloc_idx;
               end
            end
            OP_MARK: begin
               if (sel_ok && !svc_q[cmd_idx]) begin
                  if (cmd_flag) vld_n[cmd_idx] = 1'b0;
                  else          svc_n[cmd_idx] = 1'b1;
               end
            end
            OP_PEND: begin
               if (sel_ok && svc_q[cmd_idx]) begin
                  svc_n[cmd_idx] = 1'b0;
                  ins_v = 1'b1;
               end
            end
            OP_FRONT: begin
               frt_v = sel_ok && !svc_q[cmd_idx];
            end
            OP_FREE: begin
               if (sel_ok) begin
                  vld_n[cmd_idx] = 1'b0;
                  svc_n[cmd_idx] = 1'b0;
               end
            end
            OP_SQUASH: begin
               for (int i = 0; i < PHYS; i++)
                  if (vld_q[i] && !svc_q[i] && tid_q[i] == cmd_tid) vld_n[i] = 1'b0;
            end
            OP_DRAIN: begin
            end
            OP_TPOP: begin
               if (sel_ok && cmd_flag) begin
                  vld_n[cmd_idx] = 1'b0;
                  svc_n[cmd_idx] = 1'b0;
                  unfull_n = full && !((free_cnt + 1) <= int'(RESERVE));
               end
            end
            default: begin
            end
         endcase
      end
      if (issue_fire) svc_n[head_idx] = 1'b1;
   end

   assign next_cnt = $countones(vld_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q        <= '0;
         svc_q        <= '0;
         addr_q       <= '0;
         sec_q        <= '0;
         tid_q        <= '0;
         time_q       <= '0;
         alloc_err_q  <= 1'b0;
         unfull_q     <= 1'b0;
         drain_done_q <= 1'b0;
         draining_q   <= 1'b0;
      end else begin
         vld_q       <= vld_n;
         svc_q       <= svc_n;
         alloc_err_q <= err_n;
         unfull_q    <= unfull_n;
         if (wr_en) begin
            addr_q[alloc_idx] <= cmd_addr;
            sec_q[alloc_idx]  <= cmd_secure;
            tid_q[alloc_idx]  <= cmd_tid;
            time_q[alloc_idx] <= cmd_time;
         end
         drain_done_q <= 1'b0;
         if (cmd_valid && op == OP_DRAIN) begin
            if (alloc_cnt == '0) drain_done_q <= 1'b1;
            else                 draining_q   <= 1'b1;
         end else if (draining_q && next_cnt == 0) begin
            drain_done_q <= 1'b1;
            draining_q   <= 1'b0;
         end
      end
   end

   assign alloc_err    = alloc_err_q;
   assign unfull_pulse = unfull_q;
   assign drain_done   = drain_done_q;
   assign draining     = draining_q;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
   parameter int unsigned ENTRIES = 5,
   parameter int unsigned IW      = 3,
   parameter int unsigned CW      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [2:0]         cmd_op,
   input logic               issue_valid,
   input logic               issue_ready,
   input logic               lk_hit,
   input logic [IW-1:0]      lk_idx,
   input logic [ENTRIES-1:0] lk_mask,
   input logic               pd_hit,
   input logic               full,
   input logic [CW-1:0]      alloc_cnt,
   input logic [CW-1:0]      svc_cnt,
   input logic               alloc_err,
   input logic               unfull_pulse,
   input logic               drain_done,
   input logic               draining
);
   // R1, R6: in-service entries are a subset of allocated ones
   a_r1_svc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      svc_cnt <= alloc_cnt);

   a_r2_refused_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd0 && full |=> alloc_err && $stable(alloc_cnt));

   a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd0 && !full |=> alloc_cnt == $past(alloc_cnt) + 1'b1);

   a_r3_idx_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_mask[lk_idx]);

   a_r4_pending_subset: assert property (@(posedge clk) disable iff (!rst_n)
      pd_hit |-> lk_hit);

   a_r6_quiet_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !issue_valid);

   a_r6_take_counts: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_ready |=> svc_cnt == $past(svc_cnt) + 1'b1);

   a_r12_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> alloc_cnt == '0);

   a_r12_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(draining) |-> drain_done);

   a_r13_unfull_real: assert property (@(posedge clk) disable iff (!rst_n)
      unfull_pulse |-> !full);
endmodule

bind mshr_file mshr_file_chk #(.ENTRIES(PHYS), .IW(IW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .issue_valid(issue_valid), .issue_ready(issue_ready), .lk_hit(lk_hit),
   .lk_idx(lk_idx), .lk_mask(lk_mask), .pd_hit(pd_hit), .full(full),
   .alloc_cnt(alloc_cnt), .svc_cnt(svc_cnt), .alloc_err(alloc_err),
   .unfull_pulse(unfull_pulse), .drain_done(drain_done), .draining(draining));

// File: tb/mshr_file_bench.sv
module mshr_file_bench;
   localparam int P = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [2:0]  cmd_idx = '0;
   logic [15:0] cmd_addr = '0;
   logic        cmd_secure = 1'b0;
   logic [1:0]  cmd_tid = '0;
   logic [7:0]  cmd_time = '0;
   logic        cmd_flag = 1'b0;
   logic [7:0]  now_time = '0;
   logic [15:0] lk_addr = '0;
   logic        lk_secure = 1'b0;
   logic        issue_ready = 1'b0;
   logic        lk_hit, pd_hit, issue_valid, full, alloc_err, unfull_pulse, drain_done, draining;
   logic [2:0]  lk_idx, pd_idx, issue_idx, alloc_idx, alloc_cnt, svc_cnt;
   logic [P-1:0] lk_mask;
   logic [15:0] issue_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mshr_file u_mshr_file (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_addr(cmd_addr), .cmd_secure(cmd_secure),
      .cmd_tid(cmd_tid), .cmd_time(cmd_time), .cmd_flag(cmd_flag),
      .now_time(now_time), .lk_addr(lk_addr), .lk_secure(lk_secure),
      .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_mask(lk_mask), .pd_hit(pd_hit),
      .pd_idx(pd_idx), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_idx(issue_idx), .issue_addr(issue_addr), .alloc_idx(alloc_idx),
      .full(full), .alloc_cnt(alloc_cnt), .svc_cnt(svc_cnt),
      .alloc_err(alloc_err), .unfull_pulse(unfull_pulse),
      .drain_done(drain_done), .draining(draining));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_valid = 1'b0; issue_ready = 1'b0; now_time = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cmd(input int op, input int idx, input int addr, input bit sec,
                      input int tid, input int tim, input bit flag);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = 3'(idx); cmd_addr = 16'(addr);
      cmd_secure = sec; cmd_tid = 2'(tid); cmd_time = 8'(tim); cmd_flag = flag;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_flag = 1'b0;
   endtask

   task automatic alloc(input int addr, input bit sec, input int tid, input int tim);
      cmd(0, 0, addr, sec, tid, tim, 1'b0);
   endtask

   task automatic take();
      issue_ready = 1'b1;
      @(negedge clk);
      issue_ready = 1'b0;
   endtask

   task automatic look(input int addr, input bit sec);
      lk_addr = 16'(addr); lk_secure = sec; #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      look(16'h0, 1'b0);
      chk("R1 alloc_cnt", int'(alloc_cnt), 0);
      chk("R1 svc_cnt", int'(svc_cnt), 0);
      chk("R1 full", int'(full), 0);
      chk("R1 issue_valid", int'(issue_valid), 0);
      chk("R1 lk_hit", int'(lk_hit), 0);
      chk("R1 pd_hit", int'(pd_hit), 0);
      chk("R1 alloc_idx", int'(alloc_idx), 0);

      // R5/R6/R2 sweep of all ready-time patterns over three entries
      for (int code = 0; code < 27; code++) begin
         int t[3];
         bit taken[3];
         do_reset();
         now_time = 8'd3;
         t[0] = code % 3; t[1] = (code / 3) % 3; t[2] = code / 9;
         for (int k = 0; k < 3; k++) begin
            taken[k] = 1'b0;
            #1 chk("R2 alloc_idx", int'(alloc_idx), k);
            alloc(16'h100 + k, 1'b0, 0, t[k]);
         end
         #1;
         chk("R2 alloc_cnt", int'(alloc_cnt), 3);
         chk("R2 full", int'(full), 1);
         for (int s = 0; s < 3; s++) begin
            int best;
            best = -1;
            for (int k = 0; k < 3; k++)
               if (!taken[k] && (best < 0 || t[k] < t[best])) best = k;
            taken[best] = 1'b1;
            #1;
            chk("R5 issue_valid", int'(issue_valid), 1);
            chk("R5 issue_idx", int'(issue_idx), best);
            chk("R5 issue_addr", int'(issue_addr), 16'h100 + best);
            take();
         end
         #1;
         chk("R6 svc_cnt", int'(svc_cnt), 3);
         chk("R6 issue_valid empty", int'(issue_valid), 0);
      end

      // R5 due gating, R6 quiet during command
      do_reset();
      now_time = 8'd5;
      alloc(16'h10, 1'b0, 0, 10);
      #1 chk("R5 not due", int'(issue_valid), 0);
      now_time = 8'd10;
      #1 chk("R5 due", int'(issue_valid), 1);
      cmd_valid = 1'b1; cmd_op = 3'd4; cmd_idx = 3'd4; #1;
      chk("R6 quiet on cmd", int'(issue_valid), 0);
      @(negedge clk); cmd_valid = 1'b0; #1;
      chk("R9 free of empty slot ignored", int'(alloc_cnt), 1);

      // R2 refused allocation
      alloc(16'h11, 1'b0, 0, 0);
      alloc(16'h12, 1'b0, 0, 0);
      #1 chk("R2 full at 3", int'(full), 1);
      alloc(16'h13, 1'b0, 0, 0);
      #1;
      chk("R2 alloc_err", int'(alloc_err), 1);
      chk("R2 count kept", int'(alloc_cnt), 3);
      look(16'h13, 1'b0);
      chk("R2 refused not stored", int'(lk_hit), 0);
      @(negedge clk); #1 chk("R2 alloc_err one cycle", int'(alloc_err), 0);

      // R3/R4/R7 lookups
      do_reset();
      alloc(16'h40, 1'b0, 0, 0);
      alloc(16'h40, 1'b1, 0, 0);
      alloc(16'h40, 1'b0, 0, 0);
      look(16'h40, 1'b0);
      chk("R3 hit", int'(lk_hit), 1);
      chk("R3 idx", int'(lk_idx), 0);
      chk("R3 mask", int'(lk_mask), 5);
      look(16'h40, 1'b1);
      chk("R3 secure idx", int'(lk_idx), 1);
      chk("R3 secure mask", int'(lk_mask), 2);
      look(16'h41, 1'b0);
      chk("R3 miss", int'(lk_hit), 0);
      cmd(1, 0, 0, 0, 0, 0, 1'b0);
      look(16'h40, 1'b0);
      chk("R7 svc_cnt", int'(svc_cnt), 1);
      chk("R4 pd_idx skips in-service", int'(pd_idx), 2);
      chk("R4 lk_idx keeps in-service", int'(lk_idx), 0);
      cmd(1, 2, 0, 0, 0, 0, 1'b0);
      look(16'h40, 1'b0);
      chk("R4 pd miss", int'(pd_hit), 0);
      cmd(1, 1, 0, 0, 0, 0, 1'b1);
      look(16'h40, 1'b1);
      chk("R7 finish frees", int'(lk_hit), 0);
      chk("R7 alloc_cnt", int'(alloc_cnt), 2);

      // R8 return to pending goes behind equal times
      do_reset();
      now_time = 8'd20;
      alloc(16'h50, 1'b0, 0, 5);
      alloc(16'h51, 1'b0, 0, 5);
      alloc(16'h52, 1'b0, 0, 9);
      #1 chk("R8 head first", int'(issue_idx), 0);
      take();
      cmd(2, 0, 0, 0, 0, 0, 1'b0);
      #1;
      chk("R8 svc_cnt back", int'(svc_cnt), 0);
      chk("R8 order a", int'(issue_idx), 1);
      take();
      #1 chk("R8 order b", int'(issue_idx), 0);
      take();
      #1 chk("R8 order c", int'(issue_idx), 2);

      // R10 move to front
      do_reset();
      now_time = 8'd20;
      alloc(16'h60, 1'b0, 0, 1);
      alloc(16'h61, 1'b0, 0, 2);
      alloc(16'h62, 1'b0, 0, 3);
      cmd(3, 2, 0, 0, 0, 0, 1'b0);
      #1 chk("R10 fronted head", int'(issue_idx), 2);
      cmd(3, 1, 0, 0, 0, 0, 1'b0);
      #1 chk("R10 newest front", int'(issue_idx), 1);
      take();
      cmd(3, 1, 0, 0, 0, 0, 1'b0);
      #1 chk("R10 in-service unaffected", int'(issue_idx), 2);

      // R9 free of pending entry
      do_reset();
      now_time = 8'd20;
      alloc(16'h70, 1'b0, 0, 1);
      alloc(16'h71, 1'b0, 0, 2);
      cmd(4, 0, 0, 0, 0, 0, 1'b0);
      #1;
      chk("R9 head moves", int'(issue_idx), 1);
      chk("R9 alloc_cnt", int'(alloc_cnt), 1);

      // R11 squash
      do_reset();
      alloc(16'h80, 1'b0, 1, 0);
      alloc(16'h81, 1'b0, 2, 0);
      alloc(16'h82, 1'b0, 1, 0);
      cmd(1, 2, 0, 0, 0, 0, 1'b0);
      cmd(5, 0, 0, 0, 1, 0, 1'b0);
      #1 chk("R11 alloc_cnt", int'(alloc_cnt), 2);
      look(16'h80, 1'b0); chk("R11 pending freed", int'(lk_hit), 0);
      look(16'h82, 1'b0); chk("R11 in-service kept", int'(lk_hit), 1);
      look(16'h81, 1'b0); chk("R11 other thread kept", int'(lk_hit), 1);

      // R12 drain
      do_reset();
      cmd(6, 0, 0, 0, 0, 0, 1'b0);
      #1;
      chk("R12 immediate done", int'(drain_done), 1);
      chk("R12 not draining", int'(draining), 0);
      @(negedge clk); #1 chk("R12 pulse ends", int'(drain_done), 0);
      alloc(16'h90, 1'b0, 0, 0);
      cmd(6, 0, 0, 0, 0, 0, 1'b0);
      #1;
      chk("R12 draining", int'(draining), 1);
      chk("R12 not yet done", int'(drain_done), 0);
      cmd(4, 0, 0, 0, 0, 0, 1'b0);
      #1;
      chk("R12 done on empty", int'(drain_done), 1);
      chk("R12 draining clears", int'(draining), 0);

      // R13 target pop
      do_reset();
      alloc(16'hA0, 1'b0, 0, 0);
      alloc(16'hA1, 1'b0, 0, 0);
      alloc(16'hA2, 1'b0, 0, 0);
      cmd(7, 1, 0, 0, 0, 0, 1'b0);
      #1;
      chk("R13 targets remain", int'(alloc_cnt), 3);
      chk("R13 no pulse", int'(unfull_pulse), 0);
      cmd(7, 1, 0, 0, 0, 0, 1'b1);
      #1;
      chk("R13 freed", int'(alloc_cnt), 2);
      chk("R13 unfull pulse", int'(unfull_pulse), 1);
      chk("R13 not full", int'(full), 0);
      cmd(7, 0, 0, 0, 0, 0, 1'b1);
      #1 chk("R13 no pulse when not full", int'(unfull_pulse), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule